// File: doc/BRIEF.md
# Three-Wire Serial Word Memory Slave

This block is a synthesizable model of a small serial memory that sits on a chip-select / serial-clock / data-in / data-out bus. It holds 256 words of 16 bits in an internal register array, and every word is reset to FFFFh. All bus inputs are asynchronous to the block. They pass through two-flop synchronisers on a fast system clock, and the rising edges of the serial clock are found by comparing consecutive samples. Data-in is captured on those edges.

A transaction begins at the first 1 on data-in after chip select rises. After that start bit come a 2-bit operation code, an 8-bit word address and, for write-type commands, a 16-bit data word. All fields are sent MSB first. The block supports several commands:
- read, with an address that advances after each word;
- single-word write;
- single-word erase;
- fill of the whole array with one value;
- whole-array erase;
- a pair of commands that set or clear a write-permission latch.

A programming command takes effect only when chip select falls after its last bit. It then runs for a fixed number of system clocks. While chip select is high again, the data line reports busy or ready.

The output is a data bit with a separate output-enable, so a pad or a shared wire can be built around it.

Top module: `mw_eeprom`

## Requirements
- R1: Zeros sampled on data-in after chip select rises are ignored. The first 1 is the start bit. Every later bit is captured on a rising serial-clock edge, MSB first.
- R2: `ser_do_oe` is 0 whenever the synchronised chip select is low, and after reset.
- R3: Opcode 10 is a read. On the serial-clock edge that captures the last address bit, `ser_do_oe` goes to 1 and `ser_do` drives 0. On each of the next 16 edges, `ser_do` drives one bit of the word, from bit 15 down to bit 0.
- R4: During a read, extra serial clocks with chip select high continue with the next address, without a gap. Address 255 is followed by address 0.
- R5: After reset the write-permission latch is clear, and programming commands then have no effect. Opcode 00 with address bits [7:6]=11 sets the latch. Opcode 00 with bits [7:6]=00 clears it. Reads work in either state.
- R6: Opcode 01 followed by 16 data bits stores that word at the address. The stored value becomes visible when the programming time ends.
- R7: Opcode 11 sets the addressed word to FFFFh. Opcode 00 with address bits [7:6]=10 sets every word to FFFFh.
- R8: Opcode 00 with address bits [7:6]=01, followed by 16 data bits, stores that value in every word in one programming cycle.
- R9: Programming starts only when chip select falls after the last required bit: data bit 0 for a write or fill, the last address bit for an erase. If chip select falls earlier, the command is dropped with no effect.
- R10: After programming starts, `ser_do_oe`=1 whenever chip select is high. `ser_do` is 0 for PROG_CYCLES system clocks and 1 afterwards. The display ends when the next start bit is accepted.
- R11: While programming is in progress, start bits are not accepted, so any command sent in that time has no effect.
- R12: After reset every word reads FFFFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be several times faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_cs | input | 1 | Chip select, active high |
| ser_clk | input | 1 | Serial clock |
| ser_di | input | 1 | Serial data in |
| ser_do | output | 1 | Serial data out / ready-busy status |
| ser_do_oe | output | 1 | Output enable for ser_do; 0 means high impedance |

## Verification
The assertions assume that each serial-clock phase lasts at least three system clocks, so that every edge is detected once. They also assume that data-in and chip select change only while the serial clock is low, so that they pass through the synchronisers together with the clock. The stimulus keeps the serial clock low or high for four system clocks per phase. It changes data-in only at the start of a low phase, and it holds chip select low for six system clocks between commands. Programming status is sampled both inside and after the PROG_CYCLES window, and never in the few clocks around its edges.

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_cs,
  input  logic ser_clk,
  input  logic ser_di,
  output logic ser_do,
  output logic ser_do_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXW  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
  localparam int CW    = $clog2(MAXW) + 1;
  localparam int BW    = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] A_LAST = CW'(ADDR_W - 1);
  localparam logic [CW-1:0] D_LAST = CW'(DATA_W - 1);
  localparam logic [CW-1:0] C_ONE  = CW'(1);
  localparam logic [BW-1:0] B_ONE  = BW'(1);
  localparam logic [ADDR_W-1:0] A_ONE = ADDR_W'(1);

  typedef enum logic [2:0] {S_IDLE, S_OP, S_ADDR, S_DATA, S_ARMED, S_READ, S_DONE} st_t;
  typedef enum logic [1:0] {K_WR, K_ER, K_WALL, K_EALL} kind_t;

  logic cs_m, cs_s, cs_d, sk_m, sk_s, sk_d, di_m, di_s;
  logic [DATA_W-1:0] mem [DEPTH];
  st_t st;
  kind_t kind;
  logic [1:0] op;
  logic [ADDR_W-1:0] adr, rptr;
  logic [DATA_W-1:0] dat, rsh;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bcnt;
  logic wen, stat, rd_oe, dout_r;

  wire sk_rise = sk_s & ~sk_d;
  wire cs_fall = cs_d & ~cs_s;
  wire busy    = bcnt != '0;
  wire [ADDR_W-1:0] adr_n = {adr[ADDR_W-2:0], di_s};
  wire [1:0] sub = adr_n[ADDR_W-1 -: 2];
  wire [ADDR_W-1:0] rnext = rptr + A_ONE;

  assign ser_do_oe = cs_s & (rd_oe | stat);
  assign ser_do    = rd_oe ? dout_r : ~busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {cs_m, cs_s, cs_d, sk_m, sk_s, sk_d, di_m, di_s} <= '0;
    else begin
      {cs_m, cs_s, cs_d} <= {ser_cs, cs_m, cs_s};
      {sk_m, sk_s, sk_d} <= {ser_clk, sk_m, sk_s};
      {di_m, di_s}       <= {ser_di, di_m};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_WR; op <= '0; adr <= '0; rptr <= '0;
      dat <= '0; rsh <= '0; cnt <= '0; bcnt <= '0;
      wen <= 1'b0; stat <= 1'b0; rd_oe <= 1'b0; dout_r <= 1'b0;
    end else begin
      if (busy) bcnt <= bcnt - B_ONE;
      if (!cs_s) begin
        if (cs_fall && st == S_ARMED && wen) begin
          bcnt <= BW'(PROG_CYCLES);
          stat <= 1'b1;
        end
        st <= S_IDLE;
        rd_oe <= 1'b0;
      end else if (sk_rise) begin
        case (st)
          S_IDLE: if (di_s && !busy) begin st <= S_OP; stat <= 1'b0; cnt <= '0; end
          S_OP: begin
            op <= {op[0], di_s};
            if (cnt == C_ONE) begin st <= S_ADDR; cnt <= '0; end
            else cnt <= cnt + C_ONE;
          end
          S_ADDR: begin
            adr <= adr_n;
            cnt <= cnt + C_ONE;
            if (cnt == A_LAST) begin
              cnt <= '0;
              case (op)
                2'b10: begin
                  st <= S_READ; rsh <= mem[adr_n]; rptr <= adr_n;
                  rd_oe <= 1'b1; dout_r <= 1'b0;
                end
                2'b01: begin st <= S_DATA; kind <= K_WR; end
                2'b11: begin st <= S_ARMED; kind <= K_ER; end
                default:
                  case (sub)
                    2'b11: begin wen <= 1'b1; st <= S_DONE; end
                    2'b00: begin wen <= 1'b0; st <= S_DONE; end
                    2'b01: begin st <= S_DATA; kind <= K_WALL; end
                    default: begin st <= S_ARMED; kind <= K_EALL; end
                  endcase
              endcase
            end
          end
          S_DATA: begin
            dat <= {dat[DATA_W-2:0], di_s};
            if (cnt == D_LAST) st <= S_ARMED;
            else cnt <= cnt + C_ONE;
          end
          S_READ: begin
            dout_r <= rsh[DATA_W-1];
            if (cnt == D_LAST) begin cnt <= '0; rptr <= rnext; rsh <= mem[rnext]; end
            else begin cnt <= cnt + C_ONE; rsh <= {rsh[DATA_W-2:0], 1'b0}; end
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (bcnt == B_ONE) begin
      case (kind)
        K_WR:   mem[adr] <= dat;
        K_ER:   mem[adr] <= '1;
        K_WALL: for (int i = 0; i < DEPTH; i++) mem[i] <= dat;
        default: for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      endcase
    end

  p_hiz_cs_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ser_cs, 2) |-> !ser_do_oe);
  p_read_dummy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && sk_rise && st == S_ADDR && cnt == A_LAST && op == 2'b10) |=> !ser_do);
  p_prog_on_cs_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_fall));
  p_mem_only_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bcnt != B_ONE) |=> $stable(mem[0]));
  p_busy_shown_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && stat && cs_s) |-> (ser_do_oe && !ser_do));
  p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && st == S_IDLE) |=> st == S_IDLE);
endmodule

// File: tb/sim_mw_eeprom.sv
`timescale 1ns/1ps
module sim_mw_eeprom;
  localparam int PROG = 200;
  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0;
  wire sdo, soe;
  int errors = 0, checks = 0;
  logic [15:0] mm [256];
  bit wen_m = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  mw_eeprom #(.ADDR_W(8), .DATA_W(16), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_cs(cs), .ser_clk(sk), .ser_di(di),
    .ser_do(sdo), .ser_do_oe(soe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask
  task automatic sk_bit(input logic b); di = b; tick(4); sk = 1'b1; tick(4); sk = 1'b0; endtask
  task automatic cs_hi; cs = 1'b1; tick(4); endtask
  task automatic cs_lo; cs = 1'b0; di = 1'b0; tick(6); endtask
  task automatic send(input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) sk_bit(v[i]);
  endtask
  task automatic cmd(input logic [1:0] op, input logic [7:0] a);
    sk_bit(1'b1); send({14'd0, op}, 2); send({8'd0, a}, 8);
  endtask

  task automatic read_words(input logic [7:0] a, input int n, input string req);
    logic [15:0] w;
    cs_hi; sk_bit(1'b1); send(16'd2, 2); send({9'd0, a[7:1]}, 7); sk_bit(a[0]);
    chk({req, " R3 dummy"}, {soe, sdo}, 2'b10);
    for (int k = 0; k < n; k++) begin
      w = '0;
      for (int b = 0; b < 16; b++) begin sk_bit(1'b0); w = {w[14:0], sdo}; end
      chk(req, w, mm[8'(a + k)]);
    end
    cs_lo;
  endtask

  task automatic prog_status(input string req);
    cs_hi; tick(2);
    chk({req, " R10 busy"}, {soe, sdo}, 2'b10);
    tick(PROG + 10);
    chk({req, " R10 ready"}, {soe, sdo}, 2'b11);
    sk_bit(1'b1);
    chk({req, " R10 cleared by start"}, soe, 1'b0);
    cs_lo;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d, input int nb, input int lead);
    cs_hi;
    for (int i = 0; i < lead; i++) sk_bit(1'b0);
    cmd(2'b01, a);
    for (int i = 15; i >= 16 - nb; i--) sk_bit(d[i]);
    cs_lo;
  endtask

  task automatic short_cmd(input logic [7:0] a);
    cs_hi; cmd(2'b00, a); cs_lo;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mm[i] = 16'hFFFF;
    tick(3); rst_n = 1'b1; tick(3);
    chk("R2 oe after reset", soe, 1'b0);
    read_words(8'h05, 2, "R12 R4 reset contents");

    wr(8'h05, 16'hA5C3, 16, 0);
    cs_hi; chk("R5 no status when write-disabled", soe, 1'b0); cs_lo;
    read_words(8'h05, 1, "R5 write ignored while disabled");

    short_cmd(8'hC0); wen_m = 1'b1;
    wr(8'h05, 16'hA5C3, 16, 3);
    chk("R2 oe with cs low", soe, 1'b0);
    prog_status("R6");
    mm[8'h05] = 16'hA5C3;
    read_words(8'h05, 2, "R1 R6 R4 write then increment");

    wr(8'hFF, 16'hBEEF, 16, 0); prog_status("R6 top"); mm[8'hFF] = 16'hBEEF;
    mm[8'h00] = 16'hFFFF;
    read_words(8'hFF, 2, "R4 wrap to address 0");

    wr(8'h06, 16'h1111, 15, 0);
    cs_hi; chk("R9 early cs fall: no programming", soe, 1'b0); cs_lo;
    read_words(8'h06, 1, "R9 aborted write");

    wr(8'h07, 16'h0F0F, 16, 0); mm[8'h07] = 16'h0F0F;
    cs_hi; cmd(2'b00, 8'h00);
    chk("R11 status held while busy", {soe, sdo}, 2'b10);
    cs_lo; tick(PROG + 10);
    wr(8'h08, 16'h7777, 16, 0); prog_status("R11 latch kept"); mm[8'h08] = 16'h7777;
    read_words(8'h07, 2, "R11 busy command ignored");

    cs_hi; cmd(2'b11, 8'h05); cs_lo; prog_status("R7 erase"); mm[8'h05] = 16'hFFFF;
    read_words(8'h04, 3, "R7 single erase");

    cs_hi; cmd(2'b00, 8'h40); send(16'h1234, 16); cs_lo; prog_status("R8 fill");
    for (int i = 0; i < 256; i++) mm[i] = 16'h1234;
    read_words(8'h00, 1, "R8 fill low");
    read_words(8'hFF, 2, "R8 fill top");

    cs_hi; cmd(2'b00, 8'h80); cs_lo; prog_status("R7 whole erase");
    for (int i = 0; i < 256; i++) mm[i] = 16'hFFFF;
    read_words(8'h10, 1, "R7 whole erase");

    wr(8'h20, 16'h0000, 16, 0); prog_status("R6 pre-disable"); mm[8'h20] = 16'h0000;
    short_cmd(8'h00); wen_m = 1'b0;
    wr(8'h20, 16'h5555, 16, 0);
    cs_hi; chk("R5 no status after disable", soe, 1'b0); cs_lo;
    read_words(8'h20, 1, "R5 write ignored after disable");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule